// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Steering

This block sits in the synthesizer loop of a tuner. It watches two pulse streams: the divided reference and the divided oscillator feedback. Both are sampled on a fast system clock and reduced to rising-edge events. A three-state phase-frequency detector turns those events into pump-up and pump-down enables. It also gives a range select for the pump current and a lock flag that status logic can read. The analog pump and the tuning amplifier are outside the block. They appear here only as the enables and the select they receive.

A small set of control bits changes how the pump is driven. One bit holds the pump idle regardless of anything else. Test settings can pin the pump to a steady sink or a steady source. Another test setting takes the two detector inputs from the serial-bus clock and data pins instead of the normal sources. A further test setting asks the neighbouring output ports to switch off. The lock monitor counts reference periods whose correction pulses stay narrow. It declares lock after a run of such periods and drops lock the moment one pulse grows too wide.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pump_up`, `pump_dn`, `cur_hi`, `port_off` and `locked` are all 0.
- R2: A rising edge on the reference input with no pending feedback edge raises `pump_up`, and a lone feedback edge raises `pump_dn`. An input that rises just after one clock edge shows at the output after the third clock edge and not after the second.
- R3: Once the lagging input also rises, both enables return to 0 (after the third clock edge). Coincident rising edges produce no pulse. `pump_up` and `pump_dn` are never 1 together.
- R4: With `pump_hold` = 1, both enables are 0 one cycle later, whatever the detector state or test setting. The detector state is kept, and it reappears one cycle after `pump_hold` returns to 0.
- R5: `cur_hi` equals the value of `cur_sel` at the previous clock edge (1 selects the high pump current).
- R6: With `test_en` = 1 and `tsel` = 3'b100 the pump sinks steadily (`pump_dn` = 1, `pump_up` = 0). With `tsel` = 3'b101 it sources steadily (`pump_up` = 1, `pump_dn` = 0). Both take effect one cycle later.
- R7: With `test_en` = 1 and `tsel` = 3'b111, the detector takes its reference from `alt_ref_in` (bus clock pin) and its feedback from `alt_fb_in` (bus data pin). Edges on `ref_in` and `fb_in` then have no effect.
- R8: `port_off` is 1, one cycle later, exactly when `test_en` = 1 and `tsel` = 3'b110. Otherwise it is 0.
- R9: `locked` becomes 1 at the second clock edge after the eighth consecutive reference edge seen without a wide pulse. A pulse whose width stays at most 2 cycles keeps the count going.
- R10: If either enable inside the detector stays high for more than 4 clock cycles (the width limit), `locked` returns to 0 on the next edge, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference pulse stream |
| fb_in | input | 1 | Divided oscillator feedback stream |
| alt_ref_in | input | 1 | Substitute reference from the bus clock pin |
| alt_fb_in | input | 1 | Substitute feedback from the bus data pin |
| pump_hold | input | 1 | 1 holds both pump enables inactive |
| test_en | input | 1 | Enables the test settings chosen by `tsel` |
| tsel | input | 3 | Test setting select |
| cur_sel | input | 1 | Pump current range request, 1 = high |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| cur_hi | output | 1 | Registered high-current select |
| port_off | output | 1 | Request to switch the neighbouring output ports off |
| locked | output | 1 | Lock flag, 1 = locked |

## Verification
A detector stuck in its up or down state shows at the ports three cycles after the input edge. The enable stays high when it should have been cleared, or never rises. A corrupted lock counter shows as `locked` rising one reference period early or late. A broken width counter shows as lock that survives a lone reference edge, or that drops on the narrow two-cycle pulses. A wrong test decode shows on the pump enables or `port_off` one cycle after the control change.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PM_DETECT = 2'd0,
        PM_SINK   = 2'd1,
        PM_SOURCE = 2'd2
    } pump_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic hi;
        logic poff;
    } drive_t;

    function automatic pump_mode_e decode_mode(input logic test_en, input logic [2:0] tsel);
        pump_mode_e m;
        m = PM_DETECT;
        if (test_en && tsel[2] && !tsel[1]) begin
            m = tsel[0] ? PM_SOURCE : PM_SINK;
        end
        return m;
    endfunction

    function automatic logic decode_alt(input logic test_en, input logic [2:0] tsel);
        return test_en && (tsel == 3'b111);
    endfunction

    function automatic logic decode_poff(input logic test_en, input logic [2:0] tsel);
        return test_en && (tsel == 3'b110);
    endfunction

endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] sig_in,
    output logic [CH-1:0] rise
);

    typedef struct packed {
        logic [CH-1:0] smp;
        logic [CH-1:0] prv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = sig_in;
        st_d.prv = st_q.smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < CH; g++) begin : g_ch
        assign rise[g] = st_q.smp[g] & ~st_q.prv[g];
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic up,
    output logic dn
);

    typedef struct packed {
        logic up;
        logic dn;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.up = st_q.up | ref_edge;
        st_d.dn = st_q.dn | fb_edge;
        if (st_d.up && st_d.dn) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    // R3: the detector state never holds both directions
    a_r3_core_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int WIDTH_MAX  = 4,
    parameter int LOCK_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_edge,
    output logic locked
);

    localparam int WW = $clog2(WIDTH_MAX + 1);
    localparam int CW = $clog2(LOCK_COUNT + 1);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [CW-1:0] good;
        logic          lock;
    } st_t;

    st_t  st_d, st_q;
    logic wide;

    always_comb begin
        st_d = st_q;
        wide = active && (st_q.width >= WW'(WIDTH_MAX));

        if (!active)                         st_d.width = '0;
        else if (st_q.width != WW'(WIDTH_MAX)) st_d.width = st_q.width + 1'b1;

        if (wide) begin
            st_d.good = '0;
            st_d.lock = 1'b0;
        end else if (ref_edge && !st_q.lock) begin
            if (st_q.good == CW'(LOCK_COUNT - 1)) st_d.lock = 1'b1;
            else                                  st_d.good = st_q.good + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;

    // R10: a pulse over the width limit removes lock on the next edge
    a_r10_wide_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !st_q.lock);

    // R9: lock is only gained on a reference edge
    a_r9_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> $past(ref_edge));

endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl #(
    parameter int WIDTH_MAX  = 4,
    parameter int LOCK_COUNT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic       alt_ref_in,
    input  logic       alt_fb_in,
    input  logic       pump_hold,
    input  logic       test_en,
    input  logic [2:0] tsel,
    input  logic       cur_sel,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       cur_hi,
    output logic       port_off,
    output logic       locked
);

    import pfd_pkg::*;

    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;

    logic [1:0]  src;
    logic [1:0]  rise;
    logic        core_up, core_dn;
    pump_mode_e  mode;
    drive_t      drv_d, drv_q;
    logic        live_q;

    always_comb begin
        if (decode_alt(test_en, tsel)) begin
            src[IDX_REF] = alt_ref_in;
            src[IDX_FB]  = alt_fb_in;
        end else begin
            src[IDX_REF] = ref_in;
            src[IDX_FB]  = fb_in;
        end
    end

    pfd_rise_det #(.CH(2)) i_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (src),
        .rise   (rise)
    );

    pfd_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (rise[IDX_REF]),
        .fb_edge  (rise[IDX_FB]),
        .up       (core_up),
        .dn       (core_dn)
    );

    pfd_lock_mon #(.WIDTH_MAX(WIDTH_MAX), .LOCK_COUNT(LOCK_COUNT)) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (core_up | core_dn),
        .ref_edge (rise[IDX_REF]),
        .locked   (locked)
    );

    always_comb begin
        mode       = decode_mode(test_en, tsel);
        drv_d      = drv_q;
        drv_d.up   = 1'b0;
        drv_d.dn   = 1'b0;
        if (!pump_hold) begin
            unique case (mode)
                PM_SINK:   drv_d.dn = 1'b1;
                PM_SOURCE: drv_d.up = 1'b1;
                default: begin
                    drv_d.up = core_up;
                    drv_d.dn = core_dn;
                end
            endcase
        end
        drv_d.hi   = cur_sel;
        drv_d.poff = decode_poff(test_en, tsel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= '0;
            live_q <= 1'b0;
        end else begin
            drv_q  <= drv_d;
            live_q <= 1'b1;
        end
    end

    assign pump_up  = drv_q.up;
    assign pump_dn  = drv_q.dn;
    assign cur_hi   = drv_q.hi;
    assign port_off = drv_q.poff;

    // R3: the enables never drive both directions
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R4: the hold bit quiets the pump one cycle later
    a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(pump_hold)) |-> (!pump_up && !pump_dn));

    // R5: the current select follows its request by one cycle
    a_r5_cur_follow: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (cur_hi == $past(cur_sel)));

    // R6: forced sink setting drives the down enable
    a_r6_forced_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(test_en && tsel == 3'b100 && !pump_hold)) |-> pump_dn);

endmodule

// File: tb/test_pfd_cp_ctrl.sv
module test_pfd_cp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0, fb_in = 1'b0, alt_ref_in = 1'b0, alt_fb_in = 1'b0;
    logic       pump_hold = 1'b0, test_en = 1'b0, cur_sel = 1'b0;
    logic [2:0] tsel = 3'b000;
    logic       pump_up, pump_dn, cur_hi, port_off, locked;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pfd_cp_ctrl i_pfd_cp_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .alt_ref_in(alt_ref_in), .alt_fb_in(alt_fb_in), .pump_hold(pump_hold),
        .test_en(test_en), .tsel(tsel), .cur_sel(cur_sel),
        .pump_up(pump_up), .pump_dn(pump_dn), .cur_hi(cur_hi),
        .port_off(port_off), .locked(locked)
    );

    // {hold, test_en, tsel[2:0], cur_sel, exp up, exp dn, exp hi, exp poff}
    localparam logic [9:0] VEC [10] = '{
        10'b000000_0000,
        10'b000001_0010,
        10'b011000_0100,
        10'b011010_1000,
        10'b011011_1010,
        10'b111010_0000,
        10'b011100_0001,
        10'b011110_0000,
        10'b010000_0000,
        10'b100001_0010
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R1 outputs after reset", {pump_up, pump_dn, cur_hi, port_off, locked}, 5'b0);
        step(1);
        chk("R1 first cycle after reset", {pump_up, pump_dn, cur_hi, port_off, locked}, 5'b0);

        for (int v = 0; v < 10; v++) begin
            {pump_hold, test_en, tsel, cur_sel} = VEC[v][9:4];
            step(2);
            chk($sformatf("R4/R5/R6/R8 vector %0d", v),
                {pump_up, pump_dn, cur_hi, port_off}, VEC[v][3:0]);
        end
        {pump_hold, test_en, tsel, cur_sel} = '0;
        step(2);

        // R5 exact latency
        cur_sel = 1'b1;
        chk("R5 select not yet applied", cur_hi, 1'b0);
        step(1);
        chk("R5 select after one edge", cur_hi, 1'b1);
        cur_sel = 1'b0;
        step(2);

        // R2 reference leads
        ref_in = 1'b1;
        step(2);
        chk("R2 up not before third edge", pump_up, 1'b0);
        step(1);
        chk("R2 up raised", {pump_up, pump_dn}, 2'b10);
        fb_in = 1'b1;
        step(3);
        chk("R3 lagging edge clears", {pump_up, pump_dn}, 2'b00);
        ref_in = 1'b0; fb_in = 1'b0;
        step(3);

        // R2 feedback leads
        fb_in = 1'b1;
        step(3);
        chk("R2 dn raised", {pump_up, pump_dn}, 2'b01);
        ref_in = 1'b1;
        step(3);
        chk("R3 dn cleared", {pump_up, pump_dn}, 2'b00);
        ref_in = 1'b0; fb_in = 1'b0;
        step(3);

        // R3 coincident edges
        ref_in = 1'b1; fb_in = 1'b1;
        step(3);
        chk("R3 coincident no pulse", {pump_up, pump_dn}, 2'b00);
        ref_in = 1'b0; fb_in = 1'b0;
        step(3);

        // R4 hold keeps state but silences pump
        pump_hold = 1'b1;
        ref_in = 1'b1;
        step(3);
        chk("R4 held pump quiet", {pump_up, pump_dn}, 2'b00);
        pump_hold = 1'b0;
        step(1);
        chk("R4 state reappears", {pump_up, pump_dn}, 2'b10);
        fb_in = 1'b1;
        step(3);
        ref_in = 1'b0; fb_in = 1'b0;
        step(3);

        // R7 alternate inputs
        test_en = 1'b1; tsel = 3'b111;
        step(2);
        ref_in = 1'b1;
        step(4);
        chk("R7 main reference ignored", {pump_up, pump_dn}, 2'b00);
        alt_ref_in = 1'b1;
        step(3);
        chk("R7 bus clock pin as reference", {pump_up, pump_dn}, 2'b10);
        fb_in = 1'b1;
        step(4);
        chk("R7 main feedback ignored", {pump_up, pump_dn}, 2'b10);
        alt_fb_in = 1'b1;
        step(3);
        chk("R7 bus data pin as feedback", {pump_up, pump_dn}, 2'b00);
        ref_in = 1'b0; fb_in = 1'b0; alt_ref_in = 1'b0; alt_fb_in = 1'b0;
        step(2);
        test_en = 1'b0; tsel = 3'b000;
        step(3);

        // R9 lock with narrow pulses
        do_reset();
        step(2);
        for (int i = 0; i < 8; i++) begin
            ref_in = 1'b1;
            step(2);
            if (i == 6) chk("R9 not locked after seven", locked, 1'b0);
            if (i == 7) chk("R9 locked after eight", locked, 1'b1);
            fb_in = 1'b1;
            step(2);
            ref_in = 1'b0;
            step(2);
            fb_in = 1'b0;
            step(4);
        end
        chk("R9 lock holds", locked, 1'b1);

        // R10 wide pulse removes lock
        ref_in = 1'b1;
        step(6);
        chk("R10 lock at width limit", locked, 1'b1);
        step(1);
        chk("R10 lock dropped", locked, 1'b0);
        fb_in = 1'b1;
        step(3);
        ref_in = 1'b0; fb_in = 1'b0;
        step(2);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule